// File: doc/BRIEF.md
# Byte FIFO with Status Word

A synchronous, byte-wide first-in first-out buffer intended to sit between a serial line engine and a processor bus. One side pushes bytes with a write strobe; the other pops them with a read strobe and receives the head byte on the following clock. A non-empty flag, a one-cycle error pulse and a 16-bit status word give a producer or consumer everything it needs to pace itself.

The status word packs the clamped log2 depth, the current fill level and two interrupt-style flags. A build-time direction parameter decides what the two flags mean. In receive use they report data available and more than half full. In transmit use they report room available and less than half full. The depth is a power of two chosen by a log2 parameter that is forced into the range 2 to 10.

Top module: `byte_status_fifo`

## Requirements
- R1: The log2 depth parameter LOG2_DEPTH is clamped to 2..10 (a value of 1 gives depth 4), and status[15:12] always holds the clamped value.
- R2: Accepted bytes are returned in the order they were written; rd_data carries the head byte on the clock after an accepted read strobe.
- R3: not_empty is 1 exactly when the fill level is nonzero.
- R4: status[11:2] holds the fill level (saturating at 1023 for depth 1024); it changes by at most one per clock.
- R5: With IS_RX=1, status[0] is 1 when the fill level is at least 1, and status[1] is 1 when the fill level exceeds half the depth.
- R6: With IS_RX=0, status[0] is 1 when at least one slot is free, and status[1] is 1 when the fill level is below half the depth.
- R7: A read strobe while empty is rejected: err is 1 on the next clock only, rd_data holds its previous value and the fill level stays zero.
- R8: A write strobe on a full FIFO with no read strobe drops the byte: err is 1 on the next clock, the fill level stays at the depth and the stored bytes read back unchanged.
- R9: Read and write strobes together on a full FIFO are both accepted: the fill level stays at the depth and err stays 0.
- R10: A synchronous active-high reset empties the FIFO and clears err; after it the status word is the clamped log2 depth in [15:12], a zero fill, and the direction flags of an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Head byte, registered |
| not_empty | output | 1 | At least one byte stored |
| err | output | 1 | One-cycle pulse after a rejected read or dropped write |
| status | output | 16 | {log2 depth, fill level, flag1, flag0} |

## Verification
The main function is exercised with short write-then-read bursts, a full fill with a distinct byte value in every slot followed by a complete drain, a write attempt on full, combined read and write on full and on empty, and reads on empty. The distinct values reveal reordering and show that a dropped byte never enters storage, while the status word checked after every clock separates off-by-one errors at the half-full and full boundaries. A second instance built with an out-of-range depth in transmit mode tells the clamping and the transmit flag meanings apart from the receive ones.

// File: rtl/byte_status_fifo.sv
module byte_status_fifo #(
  parameter int LOG2_DEPTH = 4,
  parameter bit IS_RX      = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       not_empty,
  output logic       err,
  output logic [15:0] status
);
  localparam int LD    = (LOG2_DEPTH > 10) ? 10 : ((LOG2_DEPTH < 2) ? 2 : LOG2_DEPTH);
  localparam int DEPTH = 1 << LD;
  localparam logic [LD:0] CNT_FULL = (LD+1)'(DEPTH);
  localparam logic [LD:0] CNT_HALF = (LD+1)'(DEPTH / 2);

  logic [7:0]    mem [DEPTH];
  logic [LD-1:0] wp, rp;
  logic [LD:0]   cnt;
  logic [9:0]    fill;
  logic          flag0, flag1;

  wire rd_ok = rd_en && (cnt != '0);
  wire wr_ok = wr_en && ((cnt != CNT_FULL) || rd_ok);

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      err     <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) begin
        rd_data <= mem[rp];
        rp      <= rp + 1'b1;
      end
      cnt <= cnt + (LD+1)'(wr_ok) - (LD+1)'(rd_ok);
      err <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
    end
  end

  generate
    if (LD < 10) begin : g_fill_fit
      assign fill = 10'(cnt);
    end else begin : g_fill_sat
      assign fill = cnt[LD] ? 10'h3FF : cnt[9:0];
    end
    if (IS_RX) begin : g_rx
      assign flag0 = (cnt != '0);
      assign flag1 = (cnt > CNT_HALF);
    end else begin : g_tx
      assign flag0 = (cnt != CNT_FULL);
      assign flag1 = (cnt < CNT_HALF);
    end
  endgenerate

  assign not_empty = (cnt != '0);
  assign status    = {4'(LD), fill, flag1, flag0};
endmodule

// File: rtl/byte_status_fifo_chk.sv
module byte_status_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic       not_empty,
  input logic       err,
  input logic [9:0] fill
);
  localparam int FULLV = (DEPTH > 1023) ? 1023 : DEPTH;
  localparam logic [9:0] FULL_F = 10'(FULLV);

  assert_empty_read_err_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !not_empty) |=> err);

  assert_full_drop_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && fill == FULL_F) |=> (err && fill == FULL_F));

  assert_full_both_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && fill == FULL_F) |=> (!err && fill == FULL_F));

  assert_fill_step_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((fill == $past(fill)) || (fill == $past(fill) + 10'd1) ||
                     (fill + 10'd1 == $past(fill))));

  assert_reset_empty_R10: assert property (@(posedge clk)
    $past(rst) |-> (!not_empty && !err && fill == 10'd0));
endmodule

bind byte_status_fifo byte_status_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
  .not_empty(not_empty), .err(err), .fill(status[11:2])
);

// File: tb/byte_status_fifo_bench.sv
module byte_status_fifo_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic not_empty, err;
  logic [15:0] status;

  logic s_wr = 1'b0, s_rd = 1'b0;
  logic [7:0] s_rd_data;
  logic s_ne, s_err;
  logic [15:0] s_status;

  int tests = 0, fails = 0;
  logic [7:0] mdl[$];
  logic [7:0] cmp_q[$];
  logic [7:0] last_rd = 8'h00;

  always #5 clk = ~clk;

  byte_status_fifo #(.LOG2_DEPTH(4), .IS_RX(1'b1)) u_byte_status_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .not_empty(not_empty), .err(err), .status(status));

  byte_status_fifo #(.LOG2_DEPTH(1), .IS_RX(1'b0)) u_small (
    .clk(clk), .rst(rst), .wr_en(s_wr), .wr_data(8'hA5), .rd_en(s_rd),
    .rd_data(s_rd_data), .not_empty(s_ne), .err(s_err), .status(s_status));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rx_status(int c);
    return {4'd4, 10'(c), (c > 8), (c != 0)};
  endfunction

  always @(negedge clk)
    if (cmp_q.size() > 0) begin
      logic [7:0] e;
      e = cmp_q.pop_front();
      check("R2 order", {24'h0, rd_data}, {24'h0, e});
      last_rd = e;
    end

  task automatic step(logic wr, logic [7:0] d, logic rd, string tag);
    logic rd_ok, wr_ok, exp_err;
    logic [7:0] e;
    wr_en = wr; wr_data = d; rd_en = rd;
    rd_ok = rd && (mdl.size() > 0);
    wr_ok = wr && ((mdl.size() < 16) || rd_ok);
    exp_err = (rd && !rd_ok) || (wr && !wr_ok);
    e = 8'h00;
    if (rd_ok) e = mdl.pop_front();
    if (wr_ok) mdl.push_back(d);
    @(posedge clk);
    if (rd_ok) cmp_q.push_back(e);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check({tag, " err"}, {31'h0, err}, {31'h0, exp_err});
    check({tag, " status"}, {16'h0, status}, {16'h0, rx_status(mdl.size())});
    check("R3 not_empty", {31'h0, not_empty}, {31'h0, mdl.size() != 0});
    if (rd && !rd_ok)
      check("R7 rd_data held", {24'h0, rd_data}, {24'h0, last_rd});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mdl.delete(); cmp_q.delete();
    last_rd = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    check("R10 reset status", {16'h0, status}, 32'h4000);
    check("R10 reset not_empty", {31'h0, not_empty}, 32'h0);
    check("R10 reset err", {31'h0, err}, 32'h0);
    check("R4 log2 field", {28'h0, status[15:12]}, 32'h4);
    check("R1 small log2", {28'h0, s_status[15:12]}, 32'h2);
    check("R6 small empty", {16'h0, s_status}, 32'h2003);

    step(1'b0, 8'h00, 1'b1, "R7 empty read");
    step(1'b0, 8'h00, 1'b0, "R7 err clears");

    for (int i = 0; i < 3; i++) step(1'b1, 8'h10 + 8'(i), 1'b0, "R5 burst wr");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b1, "R5 burst rd");
    step(1'b0, 8'h00, 1'b1, "R7 drained read");

    for (int i = 0; i < 16; i++) step(1'b1, 8'hC0 ^ 8'(i * 7), 1'b0, "R5 fill");
    step(1'b1, 8'hEE, 1'b0, "R8 full drop");
    step(1'b1, 8'hEF, 1'b0, "R8 full drop again");
    for (int i = 0; i < 16; i++) step(1'b0, 8'h00, 1'b1, "R8 drain");

    for (int i = 0; i < 16; i++) step(1'b1, 8'h40 + 8'(i), 1'b0, "R5 refill");
    step(1'b1, 8'h99, 1'b1, "R9 full both");
    step(1'b1, 8'h9A, 1'b1, "R9 full both again");
    for (int i = 0; i < 16; i++) step(1'b0, 8'h00, 1'b1, "R9 drain");

    step(1'b1, 8'h77, 1'b1, "R7 empty both");
    step(1'b0, 8'h00, 1'b1, "R2 read after both");

    for (int i = 0; i < 5; i++) step(1'b1, 8'h30 + 8'(i), 1'b0, "R5 pre reset");
    do_reset();
    check("R10 mid reset status", {16'h0, status}, 32'h4000);
    check("R10 mid reset not_empty", {31'h0, not_empty}, 32'h0);
    step(1'b0, 8'h00, 1'b1, "R10 read after reset");

    for (int i = 1; i <= 5; i++) begin
      int c;
      s_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      s_wr = 1'b0;
      c = (i > 4) ? 4 : i;
      check("R6 small status", {16'h0, s_status},
            {16'h0, 4'd2, 10'(c), (c < 2), (c != 4)});
      check("R1 small full err", {31'h0, s_err}, {31'h0, i > 4});
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule